// File: doc/BRIEF.md
# Write-back data cache with per-line maintenance commands

This block is a set-associative, write-back level-one data cache. Each line holds eight 32-bit words and carries one of three coherence states: Modified (dirty), Exclusive (clean) or Invalid. A CPU-side port takes one request at a time: a word load, a word store, or a line maintenance command. Every request carries a byte address. A memory-side port moves whole lines to and from main memory over a request/acknowledge handshake.

Software uses the maintenance commands to manage the cache directly. It can write a line back and drop it, write a line back and keep it, drop a line and throw away any dirty data, zero a line without reading memory, or prefetch a line. Victims are chosen from the Invalid ways first. When no way is Invalid, a per-set binary-tree pseudo-LRU picks the victim. A dirty victim is written to memory before the new line is fetched.

Top module: `dcache`

## Requirements
- R1: A line is 32 bytes, selected by its aligned address. Address bits [4:0] are ignored for every maintenance command. Memory traffic always uses addresses with bits [4:0] equal to zero. The organisation (`WAYS`, `SETS`) is a parameter, with defaults of 8 ways and 128 sets.
- R2: A load miss reads the line from memory once, returns the addressed word and installs the line Exclusive. Later loads to that line hit with no memory traffic.
- R3: A store hit updates only the cached word, with no memory traffic, and leaves the line Modified. A later load returns the stored value.
- R4: A store miss reads the line from memory and merges the stored word. The line is then Modified. Its other words keep their memory values.
- R5: Flush (`req_op`=2) on a Modified hit writes the line back once and makes it Invalid. On an Exclusive hit it makes the line Invalid without a write. On a miss it causes no traffic.
- R6: Clean (`req_op`=3) on a Modified hit writes the line back once and leaves it Exclusive. On a clean hit or a miss it does nothing.
- R7: Discard (`req_op`=4) on a hit makes the line Invalid and never writes to memory, so dirty data is lost.
- R8: Zero (`req_op`=5) sets all eight words to 0 and marks the line Modified. On a miss it allocates a way without reading memory.
- R9: Touch (`req_op`=6) and touch-for-store (`req_op`=7) fetch the line on a miss, installing it Exclusive. On a hit they do nothing.
- R10: Allocation prefers the lowest-numbered Invalid way. Otherwise a tree pseudo-LRU picks the victim, and a Modified victim is written back before the refill read.
- R11: `req_ready` is high only when the block is idle. A request is accepted when `req_valid` and `req_ready` are both high. `resp_valid` pulses for one cycle when the request completes. `mem_req` and `mem_addr` stay stable until `mem_ack`.
- R12: After reset, every line is Invalid, `req_ready` is 1, and `resp_valid` and `mem_req` are 0.
- Opcodes: load is 0 and store is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request strobe |
| req_ready | output | 1 | Idle, able to accept a request |
| req_op | input | 3 | Operation code (see the requirements) |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load result |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wline | output | 256 | Line written back |
| mem_ack | input | 1 | Memory completion strobe |
| mem_rline | input | 256 | Refill line |

## Verification
The bench runs a 4-way, 4-set instance. It fills one set with four dirty lines and then forces two evictions. A design that evicted the same way twice, or that let an Invalid way lose to the tree, would evict a still-live line and show the wrong read and write counts. A design that skipped the write-back would leave stale data in the bench memory.

Each command is exercised on a dirty hit, a clean hit and a miss, and the bench counts line reads and writes for each case. A flush that kept its line would show no refill on the next load. A clean that invalidated its line would show an extra refill. A discard that wrote back would show a write. A zero miss that fetched the line would show a read.

A store miss is checked for correct merging: the stored word is returned and the neighbouring words keep their memory values. Commands are issued with non-zero low address bits to show that the offset is ignored.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0, OP_STORE = 3'd1, OP_FLUSH = 3'd2, OP_CLEAN = 3'd3,
    OP_DISCARD = 3'd4, OP_ZERO = 3'd5, OP_TOUCH = 3'd6, OP_TOUCHST = 3'd7
  } op_e;

  typedef enum logic [1:0] {LN_I = 2'd0, LN_E = 2'd1, LN_M = 2'd2} mei_e;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_ACT, S_WB, S_FILL} fsm_e;
endpackage

// File: rtl/dcache_data.sv
// Line storage: one word-wide RAM per word lane, synchronous read.
module dcache_data #(
  parameter int DEPTH = 1024,
  parameter int WORDS = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic [AW-1:0]         raddr,
  input  logic [AW-1:0]         waddr,
  input  logic [WORDS-1:0]      wen,
  input  logic [WORDS*32-1:0]   wline,
  output logic [WORDS*32-1:0]   rline
);
  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    logic [31:0] ram [DEPTH];
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (wen[g]) ram[waddr] <= wline[g*32 +: 32];
      q <= ram[raddr];
    end
    assign rline[g*32 +: 32] = q;
  end
endmodule

// File: rtl/dcache_plru.sv
// Per-set binary-tree pseudo-LRU. Node n has children 2n+1 and 2n+2;
// a node bit of 1 points the victim search to the right subtree.
module dcache_plru #(
  parameter int WAYS = 8,
  parameter int SETS = 128,
  localparam int WW = $clog2(WAYS),
  localparam int SW = $clog2(SETS),
  localparam int NODES = WAYS - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set_idx,
  input  logic          upd,
  input  logic [WW-1:0] upd_way,
  output logic [WW-1:0] victim
);
  logic [NODES-1:0] tree [SETS];
  logic [NODES-1:0] nxt;

  always_comb begin
    int n;
    n = 0;
    for (int l = 0; l < WW; l++) n = tree[set_idx][n] ? 2*n + 2 : 2*n + 1;
    victim = WW'(n - NODES);
  end

  always_comb begin
    int c, p;
    nxt = tree[set_idx];
    c = int'(upd_way) + NODES;
    for (int l = 0; l < WW; l++) begin
      p = (c - 1) / 2;
      nxt[p] = c[0];
      c = p;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree[s] <= '0;
    end else if (upd) begin
      tree[set_idx] <= nxt;
    end
  end
endmodule

// File: rtl/dcache.sv
module dcache
  import dcache_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 128,
  parameter int LINE_WORDS = 8,
  parameter int AW = 32,
  localparam int OFFW = $clog2(LINE_WORDS * 4),
  localparam int IW = $clog2(LINE_WORDS),
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS),
  localparam int TW = AW - OFFW - SW,
  localparam int LBITS = LINE_WORDS * 32,
  localparam int DEPTH = SETS * WAYS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  output logic             resp_valid,
  output logic [31:0]      resp_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [LBITS-1:0] mem_wline,
  input  logic             mem_ack,
  input  logic [LBITS-1:0] mem_rline
);
  fsm_e state_q, nstate;
  op_e op_q;
  logic [AW-1:2] addr_q;
  logic [31:0] wdata_q, rdata_q;
  logic [WW-1:0] way_q, hit_way, inv_way, plru_way, pick_way;
  logic [TW-1:0] vtag_q;
  logic hit_q, hit, inv_any, resp_q;

  logic [TW-1:0] tag_ram [DEPTH];
  mei_e mei_q [DEPTH];

  logic [SW-1:0] set_w;
  logic [TW-1:0] tag_w;
  logic [IW-1:0] widx;
  assign set_w = addr_q[OFFW +: SW];
  assign tag_w = addr_q[AW-1 -: TW];
  assign widx  = addr_q[2 +: IW];

  function automatic logic [SW+WW-1:0] ix(input logic [SW-1:0] s, input logic [WW-1:0] w);
    return {s, w};
  endfunction

  // Tag compare and Invalid-way search across the set (lowest index wins)
  always_comb begin
    hit = 1'b0; hit_way = '0; inv_any = 1'b0; inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (mei_q[ix(set_w, WW'(w))] == LN_I) begin
        inv_any = 1'b1; inv_way = WW'(w);
      end else if (tag_ram[ix(set_w, WW'(w))] == tag_w) begin
        hit = 1'b1; hit_way = WW'(w);
      end
    end
  end
  assign pick_way = hit ? hit_way : (inv_any ? inv_way : plru_way);

  mei_e cur_st;
  assign cur_st = mei_q[ix(set_w, way_q)];

  logic [LINE_WORDS-1:0] wen;
  logic [LBITS-1:0] wline, rline;
  logic tag_we, st_we, plru_upd, done;
  mei_e st_new;

  dcache_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
    .clk(clk), .rst(rst), .set_idx(set_w), .upd(plru_upd),
    .upd_way(way_q), .victim(plru_way));

  dcache_data #(.DEPTH(DEPTH), .WORDS(LINE_WORDS)) u_data (
    .clk(clk), .raddr(ix(set_w, state_q == S_LOOK ? pick_way : way_q)),
    .waddr(ix(set_w, way_q)), .wen(wen), .wline(wline), .rline(rline));

  // Control: next state and array write strobes
  always_comb begin
    logic alloc, zero_alloc;
    nstate = state_q; wen = '0; wline = '0; tag_we = 1'b0; st_we = 1'b0;
    st_new = LN_I; plru_upd = 1'b0; done = 1'b0;
    alloc = 1'b0; zero_alloc = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid) nstate = S_LOOK;
      S_LOOK: nstate = S_ACT;
      S_ACT: begin
        case (op_q)
          OP_LOAD: if (hit_q) begin plru_upd = 1'b1; done = 1'b1; end else alloc = 1'b1;
          OP_STORE:
            if (hit_q) begin
              wen[widx] = 1'b1; wline = {LINE_WORDS{wdata_q}};
              st_we = 1'b1; st_new = LN_M; plru_upd = 1'b1; done = 1'b1;
            end else alloc = 1'b1;
          OP_FLUSH:
            if (hit_q && cur_st == LN_M) nstate = S_WB;
            else begin st_we = hit_q; st_new = LN_I; done = 1'b1; end
          OP_CLEAN:
            if (hit_q && cur_st == LN_M) nstate = S_WB;
            else done = 1'b1;
          OP_DISCARD: begin st_we = hit_q; st_new = LN_I; done = 1'b1; end
          OP_ZERO:
            if (hit_q) begin
              wen = '1; st_we = 1'b1; st_new = LN_M; plru_upd = 1'b1; done = 1'b1;
            end else alloc = 1'b1;
          default: if (hit_q) done = 1'b1; else alloc = 1'b1;
        endcase
        if (alloc) begin
          if (cur_st == LN_M) nstate = S_WB;
          else if (op_q == OP_ZERO) zero_alloc = 1'b1;
          else nstate = S_FILL;
        end
      end
      S_WB:
        if (mem_ack) begin
          case (op_q)
            OP_FLUSH: begin st_we = 1'b1; st_new = LN_I; done = 1'b1; end
            OP_CLEAN: begin st_we = 1'b1; st_new = LN_E; done = 1'b1; end
            OP_ZERO:  zero_alloc = 1'b1;
            default:  nstate = S_FILL;
          endcase
        end
      S_FILL:
        if (mem_ack) begin
          wen = '1; wline = mem_rline;
          if (op_q == OP_STORE) wline[int'(widx)*32 +: 32] = wdata_q;
          tag_we = 1'b1; st_we = 1'b1;
          st_new = (op_q == OP_STORE) ? LN_M : LN_E;
          plru_upd = 1'b1; done = 1'b1;
        end
      default: nstate = S_IDLE;
    endcase
    if (zero_alloc) begin
      wen = '1; wline = '0; tag_we = 1'b1; st_we = 1'b1; st_new = LN_M;
      plru_upd = 1'b1; done = 1'b1;
    end
    if (done) nstate = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_ram[ix(set_w, way_q)] <= tag_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mei_q[i] <= LN_I;
    end else if (st_we) begin
      mei_q[ix(set_w, way_q)] <= st_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE; resp_q <= 1'b0; op_q <= OP_LOAD; addr_q <= '0;
      wdata_q <= '0; rdata_q <= '0; way_q <= '0; hit_q <= 1'b0; vtag_q <= '0;
    end else begin
      state_q <= nstate;
      resp_q  <= done;
      if (state_q == S_IDLE && req_valid) begin
        op_q <= op_e'(req_op); addr_q <= req_addr[AW-1:2]; wdata_q <= req_wdata;
      end
      if (state_q == S_LOOK) begin
        way_q <= pick_way; hit_q <= hit;
        vtag_q <= tag_ram[ix(set_w, pick_way)];
      end
      if (state_q == S_ACT && op_q == OP_LOAD && hit_q)
        rdata_q <= rline[int'(widx)*32 +: 32];
      if (state_q == S_FILL && mem_ack && op_q == OP_LOAD)
        rdata_q <= mem_rline[int'(widx)*32 +: 32];
    end
  end

  assign req_ready  = (state_q == S_IDLE);
  assign resp_valid = resp_q;
  assign resp_rdata = rdata_q;
  assign mem_req    = (state_q == S_WB) || (state_q == S_FILL);
  assign mem_we     = (state_q == S_WB);
  assign mem_addr   = {(state_q == S_WB) ? vtag_q : tag_w, set_w, OFFW'(0)};
  assign mem_wline  = rline;
endmodule

// File: rtl/dcache_chk.sv
module dcache_chk #(
  parameter int AW = 32,
  parameter int OFFW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          resp_valid,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [2:0]    op_q
);
  assert_line_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[OFFW-1:0] == '0);
  assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_discard_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> op_q != 3'd4);
  assert_zero_noread_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |-> op_q inside {3'd0, 3'd1, 3'd6, 3'd7});
  assert_reset_state_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> req_ready && !resp_valid && !mem_req);
endmodule

bind dcache dcache_chk #(.AW(AW), .OFFW(OFFW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .resp_valid(resp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .op_q(op_q));

// File: tb/dcache_bench.sv
`timescale 1ns/1ps
module dcache_bench;
  localparam int WAYS = 4, SETS = 4;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready, resp_valid, mem_req, mem_we;
  logic mem_ack = 0;
  logic [2:0] req_op = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, resp_rdata, mem_addr;
  logic [255:0] mem_wline, mem_rline = '0;

  dcache #(.WAYS(WAYS), .SETS(SETS)) u_dcache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
    .mem_ack(mem_ack), .mem_rline(mem_rline));

  always #10 clk = ~clk;

  // Main-memory model: 64 lines, ack after a short wait
  logic [255:0] bmem [64];
  logic written [64];
  int rd_cnt = 0, wr_cnt = 0, wait_cnt = 0;
  int nchk = 0, nfail = 0;

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return 32'h5A00_0000 | {18'd0, a[10:5], 8'd0} | {29'd0, a[4:2]};
  endfunction
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (written[a[10:5]]) return bmem[a[10:5]][int'(a[4:2])*32 +: 32];
    return init_word(a);
  endfunction
  function automatic logic [31:0] adr(input int tag, input int set, input int word);
    return 32'(tag * 128 + set * 32 + word * 4);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) written[i] <= 1'b0;
      mem_ack <= 1'b0; wait_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; wait_cnt <= 0;
    end else if (mem_req) begin
      if (wait_cnt == 2) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          bmem[mem_addr[10:5]] <= mem_wline; written[mem_addr[10:5]] <= 1'b1;
          wr_cnt <= wr_cnt + 1;
        end else begin
          for (int j = 0; j < 8; j++)
            mem_rline[j*32 +: 32] <= mem_word({mem_addr[31:5], 5'd0} + 32'(j*4));
          rd_cnt <= rd_cnt + 1;
        end
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [31:0] got;
  int drd, dwr;
  task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (req_ready) chk("R11", "ready while busy", 32'(req_ready), 32'd0);
    while (!resp_valid) @(negedge clk);
    got = resp_rdata;
    @(negedge clk);
    if (resp_valid) chk("R11", "resp pulse width", 32'(resp_valid), 32'd0);
    drd = rd_cnt - r0; dwr = wr_cnt - w0;
  endtask

  task automatic traffic(input string req, input int er, input int ew);
    chk(req, "line reads", 32'(drd), 32'(er));
    chk(req, "line writes", 32'(dwr), 32'(ew));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R11 watchdog expired: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R12: reset state
    chk("R12", "req_ready", 32'(req_ready), 32'd1);
    chk("R12", "resp_valid", 32'(resp_valid), 32'd0);
    chk("R12", "mem_req", 32'(mem_req), 32'd0);

    // R10: fill set 3 with four dirty lines (invalid ways first)
    for (int t = 1; t <= 4; t++) begin
      run(3'd1, adr(t, 3, 0), 32'hD000_0000 | 32'(t));
      traffic("R10", 1, 0);
    end
    run(3'd0, adr(5, 3, 0), 0);       // victim way0 (tag1), dirty
    traffic("R10", 1, 1);
    chk("R10", "evicted data", mem_word(adr(1, 3, 0)), 32'hD000_0001);
    chk("R2", "load miss data", got, init_word(adr(5, 3, 0)));
    run(3'd0, adr(2, 3, 0), 0);
    traffic("R10", 0, 0);
    chk("R3", "hit returns store", got, 32'hD000_0002);
    run(3'd0, adr(1, 3, 0), 0);       // tree now points at way2 (tag3)
    traffic("R10", 1, 1);
    chk("R10", "reload data", got, 32'hD000_0001);
    chk("R10", "second victim data", mem_word(adr(3, 3, 0)), 32'hD000_0003);
    run(3'd0, adr(4, 3, 0), 0);
    traffic("R10", 0, 0);

    // R2: load sweep, tag 0 across all sets
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 8; w++) begin
        run(3'd0, adr(0, s, w), 0);
        chk("R2", "sweep reads", 32'(drd), (w == 0) ? 32'd1 : 32'd0);
        chk("R2", "sweep data", got, init_word(adr(0, s, w)));
      end

    // R3: store hits touch only the cache
    for (int s = 0; s < 3; s++)
      for (int w = 0; w < 8; w++) begin
        run(3'd1, adr(0, s, w), 32'hC0DE_0000 | adr(0, s, w));
        traffic("R3", 0, 0);
        run(3'd0, adr(0, s, w), 0);
        chk("R3", "readback", got, 32'hC0DE_0000 | adr(0, s, w));
      end
    chk("R3", "memory untouched", mem_word(adr(0, 1, 4)), init_word(adr(0, 1, 4)));

    // R6 / R1: clean with offset bits set
    run(3'd3, adr(0, 0, 7) + 3, 0);
    traffic("R6", 0, 1);
    for (int w = 0; w < 8; w++)
      chk("R6", "written line", mem_word(adr(0, 0, w)), 32'hC0DE_0000 | adr(0, 0, w));
    run(3'd3, adr(0, 0, 0), 0);
    traffic("R6", 0, 0);
    run(3'd0, adr(0, 0, 1), 0);
    traffic("R6", 0, 0);

    // R5: flush dirty, flush clean, flush miss
    run(3'd2, adr(0, 1, 2) + 1, 0);
    traffic("R5", 0, 1);
    chk("R5", "flushed data", mem_word(adr(0, 1, 5)), 32'hC0DE_0000 | adr(0, 1, 5));
    run(3'd0, adr(0, 1, 1), 0);
    traffic("R5", 1, 0);
    chk("R5", "refetch data", got, 32'hC0DE_0000 | adr(0, 1, 1));
    run(3'd2, adr(0, 1, 0), 0);
    traffic("R5", 0, 0);
    run(3'd0, adr(0, 1, 0), 0);
    traffic("R5", 1, 0);
    run(3'd2, adr(9, 1, 0), 0);
    traffic("R5", 0, 0);

    // R7: discard drops dirty data
    run(3'd4, adr(0, 2, 3) + 2, 0);
    traffic("R7", 0, 0);
    run(3'd0, adr(0, 2, 1), 0);
    traffic("R7", 1, 0);
    chk("R7", "stale memory value", got, init_word(adr(0, 2, 1)));

    // R8: zero miss without a read, then write it back
    run(3'd5, adr(6, 2, 5) + 1, 0);
    traffic("R8", 0, 0);
    for (int w = 0; w < 8; w++) begin
      run(3'd0, adr(6, 2, w), 0);
      chk("R8", "zero word", got, 32'd0);
    end
    run(3'd3, adr(6, 2, 0), 0);
    traffic("R8", 0, 1);
    chk("R8", "zero in memory", mem_word(adr(6, 2, 6)), 32'd0);
    run(3'd5, adr(0, 0, 3), 0);       // zero hit
    traffic("R8", 0, 0);
    run(3'd0, adr(0, 0, 4), 0);
    chk("R8", "zero hit word", got, 32'd0);

    // R9: touch and touch-for-store
    run(3'd6, adr(7, 1, 0), 0);
    traffic("R9", 1, 0);
    run(3'd0, adr(7, 1, 2), 0);
    traffic("R9", 0, 0);
    chk("R9", "touched data", got, init_word(adr(7, 1, 2)));
    run(3'd7, adr(7, 1, 1), 0);
    traffic("R9", 0, 0);
    run(3'd7, adr(10, 1, 0), 0);
    traffic("R9", 1, 0);

    // R4: store miss merges into refilled line
    run(3'd1, adr(8, 0, 5), 32'h0000_BEEF);
    traffic("R4", 1, 0);
    run(3'd0, adr(8, 0, 5), 0);
    traffic("R4", 0, 0);
    chk("R4", "merged word", got, 32'h0000_BEEF);
    run(3'd0, adr(8, 0, 2), 0);
    chk("R4", "neighbour word", got, init_word(adr(8, 0, 2)));
    chk("R4", "memory not written", mem_word(adr(8, 0, 5)), init_word(adr(8, 0, 5)));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule